// File: doc/BRIEF.md
# In-Group Store-to-Load Overlap Detector

This block sits beside an instruction scheduler that forms dispatch groups. It holds a short table of the stores placed into the group being built. Each store is described by an access size and two address operands. An operand is either a register, named by a tag, or a signed constant. When the scheduler proposes a load, the block tells it in the same cycle whether the load may read bytes that one of the recorded stores writes. If so, the scheduler inserts a no-op instead of the load.

A one-cycle store strobe adds an entry to the table. A group-end strobe empties it. Access sizes arrive already encoded: the block does not decode opcodes.

A load hits an entry in any of these cases:
- its two operands equal the entry's operands in the same order;
- its two operands equal the entry's operands in swapped order;
- its second operand equals the entry's second operand, both first operands are constants, and the two byte ranges overlap.

Top module: `olap_detect`

## Requirements
- R1: A size code selects the access width: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8 and 4 means 16. Codes 5 to 7 are treated as 16 bytes. This applies to loads and to stores.
- R2: `ld_conflict` is 1 when a valid entry has first and second operands equal to the load's first and second operands, in that order.
- R3: `ld_conflict` is 1 when the load's first operand equals an entry's second operand and the load's second operand equals that entry's first operand.
- R4: Suppose the second operands match, both first operands are constants, and the store constant is below the load constant. There is a conflict exactly when the store constant plus the store size exceeds the load constant. The comparison is signed.
- R5: In the same range case with the load constant at or below the store constant, there is a conflict exactly when the load constant plus the load size exceeds the store constant.
- R6: `ld_conflict` is 0 whenever `ld_vld` is 0. It is also 0 while the table holds no store, which includes the cycles in reset.
- R7: `grp_end` clears every entry at the clock edge. Loads in that same cycle still see the old entries. A store strobed in the same cycle as `grp_end` becomes the only entry of the new group.
- R8: The table holds 5 entries (parameter DEPTH). A store strobed while the table is full and `grp_end` is low raises `st_overflow` in that cycle and is not recorded.
- R9: A store strobed in the same cycle as a load is not seen by that load. It is seen from the next cycle on.
- R10: Operand equality works as follows. Two constants are equal when their values are equal, and their tags are ignored. Two registers are equal when their tags are equal, and their values are ignored. A constant never equals a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| grp_end | input | 1 | Dispatch group ends at this edge |
| st_vld | input | 1 | Store issued this cycle |
| st_size | input | 3 | Store size code |
| st_op1_tag | input | 5 | Store first operand register tag |
| st_op1_isk | input | 1 | Store first operand is a constant |
| st_op1_k | input | 16 | Store first operand constant value |
| st_op2_tag | input | 5 | Store second operand register tag |
| st_op2_isk | input | 1 | Store second operand is a constant |
| st_op2_k | input | 16 | Store second operand constant value |
| ld_vld | input | 1 | Load candidate present |
| ld_size | input | 3 | Load size code |
| ld_op1_tag | input | 5 | Load first operand register tag |
| ld_op1_isk | input | 1 | Load first operand is a constant |
| ld_op1_k | input | 16 | Load first operand constant value |
| ld_op2_tag | input | 5 | Load second operand register tag |
| ld_op2_isk | input | 1 | Load second operand is a constant |
| ld_op2_k | input | 16 | Load second operand constant value |
| ld_conflict | output | 1 | Load overlaps a recorded store; insert a no-op |
| st_overflow | output | 1 | Store dropped because the table is full |

## Verification
Two situations are hard to reach from the ports: a full table that receives a sixth store, and a group end that coincides with a new store. To reach them, the stimulus first fills all five slots with stores on distinct base registers. It then strobes a sixth store and probes with loads that match the dropped store and the last kept store. Next it strobes `grp_end` together with a store, and shows that only that store survives. The range cases are probed with loads whose byte ranges touch the store's end or start exactly, at every size code and at negative offsets.

// File: rtl/olap_pkg.sv
package olap_pkg;
  parameter int TAG_W  = 5;
  parameter int OFF_W  = 16;
  parameter int SZC_W  = 3;
  parameter int SPAN_W = 5;

  typedef struct packed {
    logic [TAG_W-1:0]        tag;
    logic                    is_k;
    logic signed [OFF_W-1:0] k;
  } opnd_t;

  typedef struct packed {
    logic [SZC_W-1:0] size;
    opnd_t            op1;
    opnd_t            op2;
  } acc_t;

  function automatic logic opnd_eq(input opnd_t a, input opnd_t b);
    logic r;
    if (a.is_k != b.is_k) r = 1'b0;
    else if (a.is_k)      r = (a.k == b.k);
    else                  r = (a.tag == b.tag);
    return r;
  endfunction

  function automatic logic [SPAN_W-1:0] span_bytes(input logic [SZC_W-1:0] c);
    logic [SPAN_W-1:0] r;
    case (c)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/olap_entry_cmp.sv
module olap_entry_cmp
  import olap_pkg::*;
(
  input  logic vld,
  input  acc_t st,
  input  acc_t ld,
  output logic hit
);
  localparam int EW = OFF_W + 2;

  logic same_order, swapped, base_eq, both_k, range_hit;
  logic signed [EW-1:0] s_lo, l_lo, s_hi, l_hi;

  always_comb begin
    same_order = opnd_eq(ld.op1, st.op1) & opnd_eq(ld.op2, st.op2);
    swapped    = opnd_eq(ld.op1, st.op2) & opnd_eq(ld.op2, st.op1);
    base_eq    = opnd_eq(ld.op2, st.op2);
    both_k     = st.op1.is_k & ld.op1.is_k;
    s_lo = EW'(st.op1.k);
    l_lo = EW'(ld.op1.k);
    s_hi = s_lo + $signed({{(EW-SPAN_W){1'b0}}, span_bytes(st.size)});
    l_hi = l_lo + $signed({{(EW-SPAN_W){1'b0}}, span_bytes(ld.size)});
    if (s_lo < l_lo) range_hit = (s_hi > l_lo);
    else             range_hit = (l_hi > s_lo);
    hit = vld & (same_order | swapped | (base_eq & both_k & range_hit));
  end
endmodule

// File: rtl/olap_store_table.sv
module olap_store_table
  import olap_pkg::*;
#(
  parameter int DEPTH  = 5,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_end,
  input  logic              st_vld,
  input  acc_t              st_acc,
  output logic [DEPTH-1:0]  ent_vld,
  output acc_t              ent [DEPTH],
  output logic [FILL_W-1:0] fill,
  output logic              overflow
);
  logic [DEPTH-1:0]  vld_q, vld_nxt, wr_en;
  logic [FILL_W-1:0] fill_q, fill_nxt;
  logic              full;

  assign full     = (fill_q == FILL_W'(DEPTH));
  assign overflow = st_vld & ~grp_end & full;

  always_comb begin
    vld_nxt  = vld_q;
    fill_nxt = fill_q;
    wr_en    = '0;
    if (grp_end) begin
      vld_nxt  = '0;
      fill_nxt = '0;
      if (st_vld) begin
        vld_nxt[0] = 1'b1;
        wr_en[0]   = 1'b1;
        fill_nxt   = FILL_W'(1);
      end
    end else if (st_vld && !full) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_q == FILL_W'(i)) begin
          vld_nxt[i] = 1'b1;
          wr_en[i]   = 1'b1;
        end
      end
      fill_nxt = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      fill_q <= '0;
    end else begin
      vld_q  <= vld_nxt;
      fill_q <= fill_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    acc_t slot_q;
    always_ff @(posedge clk) begin
      if (wr_en[g]) slot_q <= st_acc;
    end
    assign ent[g] = slot_q;
  end

  assign ent_vld = vld_q;
  assign fill    = fill_q;
endmodule

// File: rtl/olap_detect.sv
module olap_detect
  import olap_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grp_end,
  input  logic                    st_vld,
  input  logic [SZC_W-1:0]        st_size,
  input  logic [TAG_W-1:0]        st_op1_tag,
  input  logic                    st_op1_isk,
  input  logic [OFF_W-1:0]        st_op1_k,
  input  logic [TAG_W-1:0]        st_op2_tag,
  input  logic                    st_op2_isk,
  input  logic [OFF_W-1:0]        st_op2_k,
  input  logic                    ld_vld,
  input  logic [SZC_W-1:0]        ld_size,
  input  logic [TAG_W-1:0]        ld_op1_tag,
  input  logic                    ld_op1_isk,
  input  logic [OFF_W-1:0]        ld_op1_k,
  input  logic [TAG_W-1:0]        ld_op2_tag,
  input  logic                    ld_op2_isk,
  input  logic [OFF_W-1:0]        ld_op2_k,
  output logic                    ld_conflict,
  output logic                    st_overflow
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  acc_t              st_acc, ld_acc;
  acc_t              ent [DEPTH];
  logic [DEPTH-1:0]  ent_vld, ent_hit;
  logic [FILL_W-1:0] fill;

  always_comb begin
    st_acc.size     = st_size;
    st_acc.op1.tag  = st_op1_tag;
    st_acc.op1.is_k = st_op1_isk;
    st_acc.op1.k    = st_op1_k;
    st_acc.op2.tag  = st_op2_tag;
    st_acc.op2.is_k = st_op2_isk;
    st_acc.op2.k    = st_op2_k;
    ld_acc.size     = ld_size;
    ld_acc.op1.tag  = ld_op1_tag;
    ld_acc.op1.is_k = ld_op1_isk;
    ld_acc.op1.k    = ld_op1_k;
    ld_acc.op2.tag  = ld_op2_tag;
    ld_acc.op2.is_k = ld_op2_isk;
    ld_acc.op2.k    = ld_op2_k;
  end

  olap_store_table #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_end  (grp_end),
    .st_vld   (st_vld),
    .st_acc   (st_acc),
    .ent_vld  (ent_vld),
    .ent      (ent),
    .fill     (fill),
    .overflow (st_overflow)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    olap_entry_cmp u_cmp (
      .vld (ent_vld[g]),
      .st  (ent[g]),
      .ld  (ld_acc),
      .hit (ent_hit[g])
    );
  end

  assign ld_conflict = ld_vld & (|ent_vld) & (|ent_hit);
endmodule

// File: rtl/olap_detect_chk.sv
module olap_detect_chk #(
  parameter int DEPTH  = 5,
  parameter int FILL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_end,
  input logic              st_vld,
  input logic              ld_vld,
  input logic              ld_conflict,
  input logic              st_overflow,
  input logic [FILL_W-1:0] fill
);
  AST_CONF_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |-> ld_vld); // R6
  AST_GROUP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grp_end) && !$past(st_vld)) |-> (fill == '0 && !ld_conflict)); // R7
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    st_overflow |-> (st_vld && !grp_end && fill == FILL_W'(DEPTH))); // R8
  AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    st_overflow |=> fill == FILL_W'(DEPTH)); // R8
  AST_STORE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && !grp_end && fill < FILL_W'(DEPTH)) |=> fill == $past(fill) + 1'b1); // R9
endmodule

bind olap_detect olap_detect_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grp_end     (grp_end),
  .st_vld      (st_vld),
  .ld_vld      (ld_vld),
  .ld_conflict (ld_conflict),
  .st_overflow (st_overflow),
  .fill        (fill)
);

// File: tb/tb_olap_detect.sv
module tb_olap_detect;
  logic clk = 1'b0;
  logic rst_n;
  logic grp_end, st_vld, ld_vld;
  logic [2:0]  st_size, ld_size;
  logic [4:0]  st_op1_tag, st_op2_tag, ld_op1_tag, ld_op2_tag;
  logic        st_op1_isk, st_op2_isk, ld_op1_isk, ld_op2_isk;
  logic [15:0] st_op1_k, st_op2_k, ld_op1_k, ld_op2_k;
  logic        ld_conflict, st_overflow;

  always #2.5 clk = ~clk;

  olap_detect dut (.*);

  typedef logic [21:0] op_t;
  function automatic op_t mk(input int tag, input bit isk, input int k);
    return {5'(tag), isk, 16'(k)};
  endfunction
  function automatic op_t R(input int tag); return mk(tag, 1'b0, 0); endfunction
  function automatic op_t K(input int k);   return mk(0, 1'b1, k);   endfunction

  bit    q_conf[$];
  bit    q_ovf[$];
  string q_req[$];
  int    total = 0, bad = 0;
  bit    running = 1'b1;

  task automatic step(input bit sv, input int ssz, input op_t s1, input op_t s2,
                      input bit lv, input int lsz, input op_t l1, input op_t l2,
                      input bit ge, input bit ec, input bit eo, input string req);
    @(negedge clk);
    st_vld = sv; st_size = 3'(ssz);
    {st_op1_tag, st_op1_isk, st_op1_k} = s1;
    {st_op2_tag, st_op2_isk, st_op2_k} = s2;
    ld_vld = lv; ld_size = 3'(lsz);
    {ld_op1_tag, ld_op1_isk, ld_op1_k} = l1;
    {ld_op2_tag, ld_op2_isk, ld_op2_k} = l2;
    grp_end = ge;
    q_conf.push_back(ec); q_ovf.push_back(eo); q_req.push_back(req);
  endtask

  task automatic st(input int sz, input op_t a, input op_t b, input bit eo, input string req);
    step(1'b1, sz, a, b, 1'b0, 0, R(0), R(0), 1'b0, 1'b0, eo, req);
  endtask
  task automatic ld(input int sz, input op_t a, input op_t b, input bit ec, input string req);
    step(1'b0, 0, R(0), R(0), 1'b1, sz, a, b, 1'b0, ec, 1'b0, req);
  endtask

  // Monitor: samples 2 ns after each drive edge and compares with the queue.
  always begin
    @(negedge clk);
    #2;
    if (q_conf.size() > 0) begin
      bit ec, eo; string rq;
      ec = q_conf.pop_front(); eo = q_ovf.pop_front(); rq = q_req.pop_front();
      total++;
      if (ld_conflict !== ec || st_overflow !== eo) begin
        bad++;
        $display("FAIL %s: conflict=%b overflow=%b expected conflict=%b overflow=%b",
                 rq, ld_conflict, st_overflow, ec, eo);
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (running) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_end = 1'b0; st_vld = 1'b0; ld_vld = 1'b0;
    st_size = '0; ld_size = '0;
    {st_op1_tag, st_op1_isk, st_op1_k} = '0; {st_op2_tag, st_op2_isk, st_op2_k} = '0;
    {ld_op1_tag, ld_op1_isk, ld_op1_k} = '0; {ld_op2_tag, ld_op2_isk, ld_op2_k} = '0;
    ld(2, K(8), R(3), 1'b0, "R6 reset");
    ld(2, K(8), R(3), 1'b0, "R6 reset");
    @(negedge clk); rst_n = 1'b1;
    ld(2, K(8), R(3), 1'b0, "R6 empty table");
    step(1'b1, 2, K(8), R(3), 1'b1, 2, K(8), R(3), 1'b0, 1'b0, 1'b0, "R9 same-cycle store");
    ld(2, K(8), R(3), 1'b1, "R2 exact");
    step(1'b0, 0, R(0), R(0), 1'b0, 2, K(8), R(3), 1'b0, 1'b0, 1'b0, "R6 no load");
    ld(2, R(3), K(8), 1'b1, "R3 swapped");
    ld(0, K(11), R(3), 1'b1, "R4 last byte");
    ld(0, K(12), R(3), 1'b0, "R4 past end");
    ld(2, K(4), R(3), 1'b0, "R5 touching");
    ld(2, K(5), R(3), 1'b1, "R5 one byte");
    ld(4, K(-8), R(3), 1'b0, "R1 16B negative touching");
    ld(4, K(-7), R(3), 1'b1, "R1 16B negative overlap");
    ld(2, K(8), R(4), 1'b0, "R10 base differs");
    ld(2, mk(9, 1'b1, 8), R(3), 1'b1, "R10 const tag ignored");
    step(1'b0, 0, R(0), R(0), 1'b1, 2, K(8), R(3), 1'b1, 1'b1, 1'b0, "R7 old table visible");
    ld(2, K(8), R(3), 1'b0, "R7 cleared");
    st(3, K(100), R(9), 1'b0, "R1 store 8B");
    ld(0, K(107), R(9), 1'b1, "R1 8B last byte");
    ld(0, K(108), R(9), 1'b0, "R1 8B past end");
    st(1, K(200), R(10), 1'b0, "R1 store 2B");
    ld(0, K(201), R(10), 1'b1, "R1 2B last byte");
    ld(0, K(202), R(10), 1'b0, "R1 2B past end");
    st(2, mk(7, 1'b0, 55), R(11), 1'b0, "R10 reg store");
    ld(2, mk(7, 1'b0, 99), mk(11, 1'b0, 3), 1'b1, "R10 reg value ignored");
    ld(2, mk(7, 1'b1, 55), R(11), 1'b0, "R10 const vs reg");
    step(1'b1, 2, K(0), R(20), 1'b0, 0, R(0), R(0), 1'b1, 1'b0, 1'b0, "R7 end with store");
    ld(2, K(100), R(9), 1'b0, "R7 old store gone");
    ld(2, K(0), R(20), 1'b1, "R7 new store kept");
    for (int i = 21; i <= 24; i++) st(2, K(0), R(i), 1'b0, "R8 fill");
    st(2, K(0), R(25), 1'b1, "R8 overflow");
    ld(2, K(0), R(25), 1'b0, "R8 dropped store");
    ld(2, K(0), R(24), 1'b1, "R8 fifth kept");
    step(1'b1, 2, K(0), R(26), 1'b0, 0, R(0), R(0), 1'b1, 1'b0, 1'b0, "R8 end while full");
    ld(2, K(0), R(26), 1'b1, "R7 store after full");
    ld(2, K(0), R(24), 1'b0, "R7 full table cleared");
    step(1'b0, 0, R(0), R(0), 1'b0, 0, R(0), R(0), 1'b0, 1'b0, 1'b0, "idle");
    @(negedge clk); @(negedge clk);
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule